// File: doc/BRIEF.md
# Pipeline Interlock Stall Unit

This block decides, every cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline may move on into execute. The pipeline has no bypass paths, so an operand can only be read from the register file once the instruction that writes it has completely left the write-back stage. The unit compares the two source register numbers of the decoding instruction against the destination register of each instruction still in flight in the execute, memory and write-back slots. If any used source is still owed a result, the unit freezes the program counter and the fetch/decode register, and it turns the slot entering execute into a bubble by clearing its control bits.

The unit also compares the two operand values read in decode and reports whether they are equal. It gates the branch decision so that a branch is never resolved from operands that are stale. The datapath, the register file and any software-side no-op insertion sit outside this block. The pipeline around it feeds the three in-flight destinations in through one flat bus: slot 0 holds the instruction in execute, slot 1 the one in memory, and slot 2 the one in write-back.

Top module: `hz_interlock`

## Requirements
- R1: When a used source register of the decoding instruction equals the destination of an in-flight instruction whose write-enable is set, in any of slots 0 (execute), 1 (memory) or 2 (write-back), the unit stalls in that same cycle.
- R2: Register number 0 never causes a stall, whichever slot writes it.
- R3: An in-flight instruction with its write-enable clear never causes a stall, and a source whose use flag is clear never causes a stall.
- R4: pc_hold, ifid_hold and idex_bubble are all high in a stall cycle and all low otherwise, including while reset is held with idle inputs.
- R5: ops_equal is high exactly when the two decode operand values are bit-for-bit identical, whether or not the unit is stalling.
- R6: take_branch is high only when the decoding instruction is a branch, ops_equal is high and the unit is not stalling in that cycle.
- R7: A load followed directly by an instruction that reads the loaded register delays that consumer's move out of decode by three cycles. Its issue comes four cycles after the load's issue instead of one.
- R8: A stream of n instructions with no dependences passes through the five stages in 5 + n - 1 cycles, with no stall cycle.
- R9: The stall lasts until the producer has left write-back. A consumer two instructions behind its producer waits two extra cycles, one three behind waits one extra cycle, and one four behind waits none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset for the embedded checks |
| id_src_a | input | REG_AW | First source register number in decode |
| id_en_a | input | 1 | First source is read by the instruction |
| id_src_b | input | REG_AW | Second source register number in decode |
| id_en_b | input | 1 | Second source is read by the instruction |
| id_is_branch | input | 1 | Decoding instruction is a compare-and-branch |
| id_val_a | input | DATA_W | Value read for the first source |
| id_val_b | input | DATA_W | Value read for the second source |
| prod_dst | input | NPROD*REG_AW | Destination numbers of slots 0..NPROD-1, slot k at bits k*REG_AW upward |
| prod_wen | input | NPROD | Write-enable of each in-flight slot |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Clear the control bits loaded into the decode/execute register |
| ops_equal | output | 1 | Decode operands are equal |
| take_branch | output | 1 | Branch resolved as taken this cycle |

## Verification
Every output is a function of the present inputs, so each stall and equality result is due in the cycle its inputs are presented. The bench drives decode and slot contents half a period before the rising edge and samples one nanosecond later, comparing against a behavioural pipeline model on every cycle. The multi-cycle results (R7, R8, R9) only show as the bench model advances its own stage registers by the stall outputs at each rising edge. The bench records the cycle in which each instruction leaves decode and the cycle in which the last one leaves write-back, and checks those counts after each program.

// File: rtl/hz_pkg.sv
package hz_pkg;

    // Number of in-flight slots that can still owe a register write
    localparam int HZ_SLOTS = 3;

    typedef enum logic [1:0] {
        SLOT_EX  = 2'd0,
        SLOT_MEM = 2'd1,
        SLOT_WB  = 2'd2
    } hz_slot_e;

    typedef struct packed {
        logic pc_hold;
        logic ifid_hold;
        logic idex_bubble;
    } hz_ctrl_t;

    function automatic hz_ctrl_t hz_ctrl_from(input logic stall);
        hz_ctrl_t c;
        c.pc_hold     = stall;
        c.ifid_hold   = stall;
        c.idex_bubble = stall;
        return c;
    endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
    parameter int REG_AW = 5,
    parameter int NPROD  = hz_pkg::HZ_SLOTS
) (
    input  logic [REG_AW-1:0]       src,
    input  logic                    en_src,
    input  logic [NPROD*REG_AW-1:0] prod_dst,
    input  logic [NPROD-1:0]        prod_wen,
    output logic [NPROD-1:0]        hit_slot,
    output logic                    hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic src_live;
    assign src_live = en_src && (src != ZERO_REG);

    for (genvar g = 0; g < NPROD; g++) begin : g_slot
        logic [REG_AW-1:0] dst_g;
        assign dst_g       = prod_dst[g*REG_AW +: REG_AW];
        assign hit_slot[g] = src_live && prod_wen[g] && (dst_g == src);
    end

    assign hit = |hit_slot;

endmodule

// File: rtl/hz_eq_cmp.sv
module hz_eq_cmp #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              eq
);
    logic [DATA_W-1:0] diff;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign diff[i] = a[i] ^ b[i];
    end

    assign eq = ~|diff;

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int DATA_W = 32,
    parameter int NPROD  = HZ_SLOTS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [REG_AW-1:0]       id_src_a,
    input  logic                    id_en_a,
    input  logic [REG_AW-1:0]       id_src_b,
    input  logic                    id_en_b,
    input  logic                    id_is_branch,
    input  logic [DATA_W-1:0]       id_val_a,
    input  logic [DATA_W-1:0]       id_val_b,
    input  logic [NPROD*REG_AW-1:0] prod_dst,
    input  logic [NPROD-1:0]        prod_wen,
    output logic                    pc_hold,
    output logic                    ifid_hold,
    output logic                    idex_bubble,
    output logic                    ops_equal,
    output logic                    take_branch
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NPROD-1:0] hit_slot_a, hit_slot_b;
    logic             hit_a, hit_b;
    logic             stall;
    logic             eq;
    hz_ctrl_t         ctrl;

    hz_src_match #(.REG_AW(REG_AW), .NPROD(NPROD)) u_match_a (
        .src      (id_src_a),
        .en_src   (id_en_a),
        .prod_dst (prod_dst),
        .prod_wen (prod_wen),
        .hit_slot (hit_slot_a),
        .hit      (hit_a)
    );

    hz_src_match #(.REG_AW(REG_AW), .NPROD(NPROD)) u_match_b (
        .src      (id_src_b),
        .en_src   (id_en_b),
        .prod_dst (prod_dst),
        .prod_wen (prod_wen),
        .hit_slot (hit_slot_b),
        .hit      (hit_b)
    );

    hz_eq_cmp #(.DATA_W(DATA_W)) u_eq (
        .a  (id_val_a),
        .b  (id_val_b),
        .eq (eq)
    );

    assign stall = hit_a || hit_b;
    assign ctrl  = hz_ctrl_from(stall);

    assign pc_hold     = ctrl.pc_hold;
    assign ifid_hold   = ctrl.ifid_hold;
    assign idex_bubble = ctrl.idex_bubble;
    assign ops_equal   = eq;
    // A branch may only resolve from operands that are no longer owed
    assign take_branch = id_is_branch && eq && !ctrl.pc_hold;

    // ---------------- embedded checks ----------------
    for (genvar g = 0; g < NPROD; g++) begin : g_chk
        assert_hit_a_stalls_R1: assert property (@(posedge clk) disable iff (rst)
            (id_en_a && id_src_a != ZERO_REG && prod_wen[g] &&
             prod_dst[g*REG_AW +: REG_AW] == id_src_a) |-> (pc_hold && idex_bubble));
        assert_hit_b_stalls_R1: assert property (@(posedge clk) disable iff (rst)
            (id_en_b && id_src_b != ZERO_REG && prod_wen[g] &&
             prod_dst[g*REG_AW +: REG_AW] == id_src_b) |-> (ifid_hold && idex_bubble));
    end

    assert_zero_reg_free_R2: assert property (@(posedge clk) disable iff (rst)
        (id_src_a == ZERO_REG && id_src_b == ZERO_REG) |-> !pc_hold);

    assert_no_wen_free_R3: assert property (@(posedge clk) disable iff (rst)
        (prod_wen == '0) |-> (!pc_hold && !ifid_hold && !idex_bubble));

    assert_unused_free_R3: assert property (@(posedge clk) disable iff (rst)
        (!id_en_a && !id_en_b) |-> (!pc_hold && !idex_bubble));

    assert_branch_gated_R6: assert property (@(posedge clk) disable iff (rst)
        take_branch |-> (id_is_branch && !pc_hold && !ifid_hold && id_val_a == id_val_b));

    assert_equal_seen_R5: assert property (@(posedge clk) disable iff (rst)
        (id_val_a == id_val_b) |-> ops_equal);

endmodule

// File: tb/tb_hz_interlock.sv
`timescale 1ns/1ps
module tb_hz_interlock;
    localparam int REG_AW = 5;
    localparam int DATA_W = 32;
    localparam int NPROD  = 3;
    localparam int MAXI   = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [REG_AW-1:0]       id_src_a, id_src_b;
    logic                    id_en_a, id_en_b, id_is_branch;
    logic [DATA_W-1:0]       id_val_a, id_val_b;
    logic [NPROD*REG_AW-1:0] prod_dst;
    logic [NPROD-1:0]        prod_wen;
    logic pc_hold, ifid_hold, idex_bubble, ops_equal, take_branch;

    hz_interlock #(.REG_AW(REG_AW), .DATA_W(DATA_W), .NPROD(NPROD)) dut (
        .clk(clk), .rst(rst),
        .id_src_a(id_src_a), .id_en_a(id_en_a),
        .id_src_b(id_src_b), .id_en_b(id_en_b),
        .id_is_branch(id_is_branch),
        .id_val_a(id_val_a), .id_val_b(id_val_b),
        .prod_dst(prod_dst), .prod_wen(prod_wen),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
        .ops_equal(ops_equal), .take_branch(take_branch)
    );

    int checks = 0;
    int fails  = 0;

    // program storage
    int n_ins;
    int p_sa[MAXI], p_ea[MAXI], p_sb[MAXI], p_eb[MAXI];
    int p_dst[MAXI], p_wen[MAXI], p_br[MAXI], p_va[MAXI], p_vb[MAXI];
    int issue_cyc[MAXI];
    int total_cyc;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        n_ins = 0;
    endtask

    task automatic add_ins(input int sa, input int ea, input int sb, input int eb,
                           input int dst, input int wen, input int br,
                           input int va, input int vb);
        p_sa[n_ins] = sa; p_ea[n_ins] = ea; p_sb[n_ins] = sb; p_eb[n_ins] = eb;
        p_dst[n_ins] = dst; p_wen[n_ins] = wen; p_br[n_ins] = br;
        p_va[n_ins] = va; p_vb[n_ins] = vb;
        n_ins++;
    endtask

    // Behavioural pipeline: stage holds instruction index, -1 is a bubble
    task automatic run_prog();
        int s_if, s_id, s_ex, s_mem, s_wb, pc, c;
        int owed[32];
        bit exp_stall;
        int exp_take;
        s_if = 0; pc = 1; s_id = -1; s_ex = -1; s_mem = -1; s_wb = -1; c = 1;
        total_cyc = -1;
        while (total_cyc < 0 && c < 500) begin
            @(negedge clk);
            id_src_a     = (s_id >= 0) ? REG_AW'(p_sa[s_id]) : '0;
            id_src_b     = (s_id >= 0) ? REG_AW'(p_sb[s_id]) : '0;
            id_en_a      = (s_id >= 0) && (p_ea[s_id] != 0);
            id_en_b      = (s_id >= 0) && (p_eb[s_id] != 0);
            id_is_branch = (s_id >= 0) && (p_br[s_id] != 0);
            id_val_a     = (s_id >= 0) ? DATA_W'(p_va[s_id]) : '0;
            id_val_b     = (s_id >= 0) ? DATA_W'(p_vb[s_id]) : '0;
            prod_dst[0*REG_AW +: REG_AW] = (s_ex  >= 0) ? REG_AW'(p_dst[s_ex])  : '0;
            prod_dst[1*REG_AW +: REG_AW] = (s_mem >= 0) ? REG_AW'(p_dst[s_mem]) : '0;
            prod_dst[2*REG_AW +: REG_AW] = (s_wb  >= 0) ? REG_AW'(p_dst[s_wb])  : '0;
            prod_wen[0] = (s_ex  >= 0) && (p_wen[s_ex]  != 0);
            prod_wen[1] = (s_mem >= 0) && (p_wen[s_mem] != 0);
            prod_wen[2] = (s_wb  >= 0) && (p_wen[s_wb]  != 0);
            // register scoreboard: writes still owed by in-flight instructions
            for (int r = 0; r < 32; r++) owed[r] = 0;
            if (s_ex  >= 0 && p_wen[s_ex]  != 0) owed[p_dst[s_ex]]++;
            if (s_mem >= 0 && p_wen[s_mem] != 0) owed[p_dst[s_mem]]++;
            if (s_wb  >= 0 && p_wen[s_wb]  != 0) owed[p_dst[s_wb]]++;
            owed[0] = 0;
            exp_stall = 1'b0;
            if (s_id >= 0) begin
                if (p_ea[s_id] != 0 && owed[p_sa[s_id]] > 0) exp_stall = 1'b1;
                if (p_eb[s_id] != 0 && owed[p_sb[s_id]] > 0) exp_stall = 1'b1;
            end
            exp_take = (s_id >= 0 && p_br[s_id] != 0 && p_va[s_id] == p_vb[s_id]
                        && !exp_stall) ? 1 : 0;
            #1;
            chk("R1 pc_hold", int'(pc_hold), int'(exp_stall));
            chk("R4 ifid_hold", int'(ifid_hold), int'(exp_stall));
            chk("R4 idex_bubble", int'(idex_bubble), int'(exp_stall));
            chk("R5 ops_equal", int'(ops_equal),
                (s_id >= 0) ? int'(p_va[s_id] == p_vb[s_id]) : 1);
            chk("R6 take_branch", int'(take_branch), exp_take);
            if (s_wb == n_ins - 1) total_cyc = c;
            // advance at the rising edge using the unit's decision
            @(posedge clk);
            s_wb = s_mem; s_mem = s_ex;
            if (pc_hold) begin
                s_ex = -1;
            end else begin
                if (s_id >= 0) issue_cyc[s_id] = c;
                s_ex = s_id; s_id = s_if;
                s_if = (pc < n_ins) ? pc : -1;
                if (pc < n_ins) pc++;
            end
            c++;
        end
        if (total_cyc < 0) chk("R8 program completed", 0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        id_src_a = '0; id_src_b = '0; id_en_a = 1'b0; id_en_b = 1'b0;
        id_is_branch = 1'b0; id_val_a = '0; id_val_b = '0;
        prod_dst = '0; prod_wen = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R4: idle inputs under reset give no stall
        chk("R4 reset pc_hold", int'(pc_hold), 0);
        chk("R4 reset idex_bubble", int'(idex_bubble), 0);
        rst = 1'b0;

        // R8: six independent instructions, 5+6-1 cycles
        clear_prog();
        add_ins(1, 1, 2, 1, 10, 1, 0, 7, 8);
        add_ins(2, 1, 3, 1, 11, 1, 0, 1, 2);
        add_ins(4, 1, 5, 1, 12, 1, 0, 3, 4);
        add_ins(6, 1, 7, 1, 13, 1, 0, 5, 6);
        add_ins(8, 1, 9, 1, 14, 1, 0, 9, 9);
        add_ins(1, 1, 3, 1, 15, 1, 0, 2, 3);
        run_prog();
        chk("R8 total cycles", total_cyc, 10);

        // R7: load then immediate consumer of loaded register
        clear_prog();
        add_ins(2, 1, 0, 0, 1, 1, 0, 0, 0);
        add_ins(1, 1, 4, 1, 3, 1, 0, 5, 6);
        run_prog();
        chk("R7 issue gap", issue_cyc[1] - issue_cyc[0], 4);
        chk("R7 total cycles", total_cyc, 9);

        // R9: consumer two behind its producer (source b)
        clear_prog();
        add_ins(1, 1, 2, 1, 5, 1, 0, 0, 1);
        add_ins(6, 1, 7, 1, 20, 1, 0, 0, 1);
        add_ins(8, 1, 5, 1, 21, 1, 0, 0, 1);
        run_prog();
        chk("R9 two-behind gap", issue_cyc[2] - issue_cyc[1], 3);

        // R9: consumer three behind
        clear_prog();
        add_ins(1, 1, 2, 1, 5, 1, 0, 0, 1);
        add_ins(6, 1, 7, 1, 20, 1, 0, 0, 1);
        add_ins(6, 1, 7, 1, 21, 1, 0, 0, 1);
        add_ins(5, 1, 8, 1, 22, 1, 0, 0, 1);
        run_prog();
        chk("R9 three-behind gap", issue_cyc[3] - issue_cyc[2], 2);

        // R9: consumer four behind waits none
        clear_prog();
        add_ins(1, 1, 2, 1, 5, 1, 0, 0, 1);
        add_ins(6, 1, 7, 1, 20, 1, 0, 0, 1);
        add_ins(6, 1, 7, 1, 21, 1, 0, 0, 1);
        add_ins(6, 1, 7, 1, 22, 1, 0, 0, 1);
        add_ins(5, 1, 5, 1, 23, 1, 0, 0, 1);
        run_prog();
        chk("R9 four-behind gap", issue_cyc[4] - issue_cyc[3], 1);

        // R2 and R3: register 0, write-enable clear, use flag clear
        clear_prog();
        add_ins(1, 1, 2, 1, 0, 1, 0, 0, 1);
        add_ins(0, 1, 0, 1, 24, 1, 0, 0, 0);
        add_ins(1, 1, 2, 1, 7, 0, 0, 0, 1);
        add_ins(7, 1, 3, 1, 25, 1, 0, 0, 1);
        add_ins(1, 1, 2, 1, 8, 1, 0, 0, 1);
        add_ins(8, 0, 8, 0, 26, 1, 0, 0, 1);
        run_prog();
        chk("R2 zero-reg gap", issue_cyc[1] - issue_cyc[0], 1);
        chk("R3 wen-clear gap", issue_cyc[3] - issue_cyc[2], 1);
        chk("R3 unused-source gap", issue_cyc[5] - issue_cyc[4], 1);

        // R5 and R6: branch waits on its source, then resolves; unequal branch
        clear_prog();
        add_ins(1, 1, 2, 1, 9, 1, 0, 0, 1);
        add_ins(9, 1, 10, 1, 0, 0, 1, 5, 5);
        add_ins(3, 1, 4, 1, 0, 0, 1, 3, 4);
        add_ins(3, 1, 4, 1, 0, 0, 1, 12, 12);
        run_prog();
        chk("R6 branch delayed", issue_cyc[1] - issue_cyc[0], 4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule